// File: doc/BRIEF.md
# Synchronous Serial Port Master

This block is the master side of a byte-wide synchronous serial link. It produces a serial clock, a data output with its own output enable, and two active-low chip enables. It also samples a serial data input. A single control word sets how the link behaves: the clock divider, which peripheral lines are enabled, whether the chip enable is released or held between bytes, the bit order, the transfer direction, which clock edge samples, and the idle level of the clock. The control word is only written while the port is idle.

A byte is started by handing it over on a valid/ready transmit stream. The stream is ready only when no frame is running and no received byte is still waiting. During a read frame the output driver is released and the eight sampled bits are offered on a valid/ready receive stream. A received byte stays on offer, unchanged, until the consumer takes it. While it waits, no new frame can start. This is the only way back-pressure reaches the transmit side.

A frame lasts seventeen half periods of the serial clock. The first is a setup half period after acceptance, with the chip enable already asserted. Sixteen clock edges follow, and the final edge ends the frame.

Top module: `ssp_master`

## Requirements
- R1: After reset, `ctrl_rdata` reads 0000h, both `ce_n` lines are high, `sclk` is high, `sdo` and `sdo_oe` are low, `tx_ready` is high and `rx_valid` is low.
- R2: The divider code in control bits [2:0] sets the half period of `sclk` to 2^code system clocks. A frame accepted at clock edge k toggles `sclk` at edges k+jH for j = 1..16 and ends at edge k+17H.
- R3: The chip-select field in bits [4:3] selects the lines. Code 00 drives no line low, 01 drives `ce_n[0]`, 10 drives `ce_n[1]` and 11 drives both. Selected lines go low from the cycle after a frame is accepted.
- R4: When bit [5] is 0, the selected lines go high when the frame ends. When bit [5] is 1, they stay low after the frame. A control write accepted while idle releases them if it changes the chip-select field or writes bit [5] as 0.
- R5: When bit [6] is 0, data moves least significant bit first in both directions. When bit [6] is 1, it moves most significant bit first.
- R6: When bit [7] is 1 (read), `sdo_oe` stays low and the eight sampled bits are delivered on `rx_data` at frame end. When bit [7] is 0 (write), `sdo_oe` is high for exactly the busy cycles and no receive byte is produced.
- R7: When bit [8] is 0, `sdo` changes on each leading edge and `sdi` is sampled on each trailing edge. When bit [8] is 1, the first bit is on `sdo` from acceptance, `sdi` is sampled on each leading edge and `sdo` changes on trailing edges.
- R8: When bit [9] is 0, `sclk` idles high and leading edges fall. When bit [9] is 1, it idles low and leading edges rise.
- R9: `ctrl_rdata[15]` reads 1 exactly while a frame runs. A control write is ignored while busy, and also in the cycle a frame is accepted.
- R10: `rx_valid` and `rx_data` hold until `rx_ready` is sampled high. While `rx_valid` is high, `tx_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 10 | Writable control fields |
| ctrl_rdata | output | 16 | Control fields with busy in bit 15 |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Port can accept a byte |
| tx_data | input | 8 | Byte to send |
| rx_valid | output | 1 | Received byte on offer |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Received byte |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| sdi | input | 1 | Serial data in |
| ce_n | output | 2 | Active-low chip enables |

## Verification
The assertions take for granted that reset is held low across at least one clock edge, and that `rx_ready` and `tx_valid` are ordinary handshake inputs that the block never has to obey within the same cycle. They make no assumption about the value of `sdi`. The stimulus changes every input on the falling clock edge and holds each transmit byte until it is accepted. It writes the control word mostly while the port is idle, and also deliberately during frames to exercise the lock. It drives `sdi` from a pseudo-random sequence so that every sampled bit position carries varied data.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int CTRL_W    = 16;
  localparam int FRAME_LEN = 8;
  localparam int DIV_W     = 3;
  localparam int CE_LINES  = 2;

  // control word field positions (bit order matters for the struct cast below)
  localparam int P_DIV_LO = 0;
  localparam int P_CE_LO  = 3;
  localparam int P_CONT   = 5;
  localparam int P_MSB    = 6;
  localparam int P_RD     = 7;
  localparam int P_LEAD   = 8;
  localparam int P_POL    = 9;
  localparam int P_BUSY   = 15;

  typedef struct packed {
    logic                pol;          // 1: idle low
    logic                lead_sample;  // 1: sample on leading edge
    logic                rd;           // 1: read frame
    logic                msb_first;
    logic                cont;         // hold chip enable between frames
    logic [CE_LINES-1:0] ce_sel;
    logic [DIV_W-1:0]    div_sel;
  } ssp_cfg_t;

  localparam int CFG_W = $bits(ssp_cfg_t);
endpackage

// File: rtl/ssp_halfclk.sv
module ssp_halfclk #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = (CNT_W'(1) << div_sel) - CNT_W'(1);
  assign tick  = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/ssp_cfg_reg.sv
module ssp_cfg_reg
  import ssp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic             lock,
  input  logic             frame_start,
  input  logic             frame_end,
  output ssp_cfg_t         cfg,
  output logic             ce_act
);
  ssp_cfg_t nxt;
  logic     wr_ok;

  assign nxt   = ssp_cfg_t'(wdata);
  assign wr_ok = we && !lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg <= '0;
    else if (wr_ok) cfg <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         ce_act <= 1'b0;
    else if (frame_start)               ce_act <= 1'b1;
    else if (frame_end && !cfg.cont)    ce_act <= 1'b0;
    else if (wr_ok && ((nxt.ce_sel != cfg.ce_sel) || !nxt.cont))
                                        ce_act <= 1'b0;
  end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            emit_first,
  input  logic [BITS-1:0] load_data,
  input  logic            msb_first,
  input  logic            shift_now,
  input  logic            sample_now,
  input  logic            finish,
  input  logic            sdi,
  output logic            sdo,
  output logic [BITS-1:0] rx_word
);
  logic [BITS-1:0] tx_sr;
  logic [BITS-1:0] rx_sr;
  logic            out_q;
  logic            head_now;
  logic            head_load;
  logic [BITS-1:0] tx_adv;
  logic [BITS-1:0] ld_adv;

  assign head_now  = msb_first ? tx_sr[BITS-1] : tx_sr[0];
  assign head_load = msb_first ? load_data[BITS-1] : load_data[0];
  assign tx_adv    = msb_first ? (tx_sr << 1) : (tx_sr >> 1);
  assign ld_adv    = msb_first ? (load_data << 1) : (load_data >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
      out_q <= 1'b0;
    end else if (load) begin
      tx_sr <= emit_first ? ld_adv : load_data;
      out_q <= emit_first ? head_load : 1'b0;
    end else if (shift_now) begin
      tx_sr <= tx_adv;
      out_q <= head_now;
    end else if (finish) begin
      out_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rx_sr <= '0;
    else if (load)       rx_sr <= '0;
    else if (sample_now) rx_sr <= msb_first ? {rx_sr[BITS-2:0], sdi}
                                            : {sdi, rx_sr[BITS-1:1]};
  end

  assign sdo     = out_q;
  assign rx_word = rx_sr;
endmodule

// File: rtl/ssp_master.sv
module ssp_master
  import ssp_pkg::*;
#(
  parameter int FRAME_BITS = FRAME_LEN
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctrl_we,
  input  logic [CFG_W-1:0]      ctrl_wdata,
  output logic [CTRL_W-1:0]     ctrl_rdata,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  input  logic [FRAME_BITS-1:0] tx_data,
  output logic                  rx_valid,
  input  logic                  rx_ready,
  output logic [FRAME_BITS-1:0] rx_data,
  output logic                  sclk,
  output logic                  sdo,
  output logic                  sdo_oe,
  input  logic                  sdi,
  output logic [CE_LINES-1:0]   ce_n
);
  localparam int HALF_EDGES = 2 * FRAME_BITS;
  localparam int HC_W       = $clog2(HALF_EDGES + 1);
  localparam int PAD_W      = CTRL_W - 1 - CFG_W;

  ssp_cfg_t              cfg;
  logic                  busy, ce_act, rx_pend, phase, tick, accept;
  logic                  last_tick, lead_tick, trail_tick, sample_now, shift_now;
  logic [HC_W-1:0]       hcnt;
  logic [FRAME_BITS-1:0] rx_q, rx_word, load_word;

  assign tx_ready   = !busy && !rx_pend;
  assign accept     = tx_valid && tx_ready;
  assign last_tick  = busy && tick && (hcnt == HC_W'(HALF_EDGES));
  assign lead_tick  = busy && tick && !hcnt[0] && (hcnt != HC_W'(HALF_EDGES));
  assign trail_tick = busy && tick && hcnt[0];
  assign sample_now = cfg.lead_sample ? lead_tick : trail_tick;
  assign shift_now  = cfg.lead_sample ? (trail_tick && (hcnt != HC_W'(HALF_EDGES - 1)))
                                      : lead_tick;
  assign load_word  = cfg.rd ? '0 : tx_data;

  ssp_cfg_reg u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (ctrl_we),
    .wdata       (ctrl_wdata),
    .lock        (busy || accept),
    .frame_start (accept),
    .frame_end   (last_tick),
    .cfg         (cfg),
    .ce_act      (ce_act)
  );

  ssp_halfclk #(.SEL_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .div_sel (cfg.div_sel),
    .tick    (tick)
  );

  ssp_shifter #(.BITS(FRAME_BITS)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .emit_first (cfg.lead_sample),
    .load_data  (load_word),
    .msb_first  (cfg.msb_first),
    .shift_now  (shift_now),
    .sample_now (sample_now),
    .finish     (last_tick),
    .sdi        (sdi),
    .sdo        (sdo),
    .rx_word    (rx_word)
  );

  // frame sequencer: setup half period, 2*FRAME_BITS edges, final half period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      hcnt  <= '0;
      phase <= 1'b0;
    end else if (accept) begin
      busy  <= 1'b1;
      hcnt  <= '0;
      phase <= 1'b0;
    end else if (busy && tick) begin
      if (last_tick) begin
        busy <= 1'b0;
      end else begin
        hcnt  <= hcnt + HC_W'(1);
        phase <= ~phase;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_pend <= 1'b0;
      rx_q    <= '0;
    end else if (last_tick && cfg.rd) begin
      rx_pend <= 1'b1;
      rx_q    <= rx_word;
    end else if (rx_pend && rx_ready) begin
      rx_pend <= 1'b0;
    end
  end

  assign sclk       = phase ^ ~cfg.pol;
  assign sdo_oe     = busy && !cfg.rd;
  assign ce_n       = ~(cfg.ce_sel & {CE_LINES{ce_act}});
  assign rx_valid   = rx_pend;
  assign rx_data    = rx_q;
  assign ctrl_rdata = {busy, {PAD_W{1'b0}}, cfg};
endmodule

// File: rtl/ssp_master_chk.sv
module ssp_master_chk
  import ssp_pkg::*;
#(
  parameter int FRAME_BITS = FRAME_LEN
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [CTRL_W-1:0]     ctrl_rdata,
  input logic                  tx_ready,
  input logic                  rx_valid,
  input logic                  rx_ready,
  input logic [FRAME_BITS-1:0] rx_data,
  input logic                  sclk,
  input logic                  sdo_oe,
  input logic [CE_LINES-1:0]   ce_n
);
  logic                busy;
  logic [CE_LINES-1:0] sel;

  assign busy = ctrl_rdata[P_BUSY];
  assign sel  = ctrl_rdata[P_CE_LO +: CE_LINES];

  a_r3_only_selected_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (~ce_n & ~sel) == '0);

  a_r4_lines_low_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ce_n == ~sel));

  a_r6_oe_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> (busy && !ctrl_rdata[P_RD]));

  a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == !ctrl_rdata[P_POL]));

  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ctrl_rdata[CFG_W-1:0]));

  a_r10_rx_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  a_r10_no_start_pending: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !tx_ready);
endmodule

bind ssp_master ssp_master_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_rdata (ctrl_rdata),
  .tx_ready   (tx_ready),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_data    (rx_data),
  .sclk       (sclk),
  .sdo_oe     (sdo_oe),
  .ce_n       (ce_n)
);

// File: tb/ssp_master_tb.sv
module ssp_master_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [9:0]  ctrl_wdata = '0;
  logic [15:0] ctrl_rdata;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [7:0]  tx_data = '0;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic [7:0]  rx_data;
  logic        sclk, sdo, sdo_oe;
  logic        sdi = 1'b0;
  logic [1:0]  ce_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssp_master u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe),
    .sdi(sdi), .ce_n(ce_n)
  );

  // behavioural reference model
  int       m_t;
  bit       m_busy, m_ce, m_rxp;
  bit [9:0] m_cfg;
  bit [7:0] m_tx, m_rx, m_rxq;

  always @(posedge clk) begin
    int h, j, idx;
    bit acc;
    if (!rst_n) begin
      m_t = 0; m_busy = 0; m_ce = 0; m_rxp = 0;
      m_cfg = '0; m_tx = '0; m_rx = '0; m_rxq = '0;
    end else begin
      h   = 1 << m_cfg[2:0];
      acc = tx_valid && !m_busy && !m_rxp;
      if (m_rxp && rx_ready) m_rxp = 0;
      if (m_busy) begin
        m_t = m_t + 1;
        if (m_t % h == 0) begin
          j = m_t / h;
          if (j == 17) begin
            m_busy = 0;
            if (!m_cfg[5]) m_ce = 0;
            if (m_cfg[7]) begin m_rxp = 1; m_rxq = m_rx; end
          end else if ((m_cfg[8] && (j % 2 == 1)) || (!m_cfg[8] && (j % 2 == 0))) begin
            idx = m_cfg[8] ? (j - 1) / 2 : j / 2 - 1;
            m_rx[m_cfg[6] ? 7 - idx : idx] = sdi;
          end
        end
      end else if (acc) begin
        m_busy = 1; m_t = 0; m_ce = 1; m_rx = '0;
        m_tx = m_cfg[7] ? 8'h00 : tx_data;
      end else if (ctrl_we) begin
        if ((ctrl_wdata[4:3] != m_cfg[4:3]) || !ctrl_wdata[5]) m_ce = 0;
        m_cfg = ctrl_wdata;
      end
    end
  end

  function automatic int edges_done();
    return m_busy ? m_t / (1 << m_cfg[2:0]) : 0;
  endfunction

  function automatic bit exp_sdo();
    int c, i;
    if (!m_busy || m_cfg[7]) return 1'b0;
    c = edges_done();
    if (m_cfg[8]) i = c / 2;
    else begin
      if (c == 0) return 1'b0;
      i = (c + 1) / 2 - 1;
    end
    if (i > 7) i = 7;
    return m_cfg[6] ? m_tx[7 - i] : m_tx[i];
  endfunction

  function automatic bit exp_sclk();
    bit ph;
    ph = edges_done() % 2;
    return m_cfg[9] ? ph : !ph;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R2 R8 sclk", {15'd0, sclk}, {15'd0, exp_sclk()});
      chk("R3 R4 ce_n", {14'd0, ce_n},
          {14'd0, ~(m_cfg[4:3] & {2{m_ce}})});
      chk("R5 R7 sdo", {15'd0, sdo}, {15'd0, exp_sdo()});
      chk("R6 sdo_oe", {15'd0, sdo_oe}, {15'd0, m_busy && !m_cfg[7]});
      chk("R9 ctrl_rdata", ctrl_rdata, {m_busy, 5'd0, m_cfg});
      chk("R10 tx_ready", {15'd0, tx_ready}, {15'd0, !m_busy && !m_rxp});
      chk("R10 rx_valid", {15'd0, rx_valid}, {15'd0, m_rxp});
      if (m_rxp) chk("R6 R10 rx_data", {8'd0, rx_data}, {8'd0, m_rxq});
    end
  end

  // pseudo-random serial input
  int seed = 32'h1234_5678;
  always @(negedge clk) begin
    seed = seed * 1103515245 + 12345;
    sdi  = seed[16];
  end

  task automatic wr_ctrl(input logic [9:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input bit poke, input int hold);
    tx_valid = 1'b1; tx_data = d;
    while (!tx_ready) @(negedge clk);
    @(negedge clk); tx_valid = 1'b0;
    if (poke) begin           // R9: write during a frame must be dropped
      repeat (3) @(negedge clk);
      ctrl_we = 1'b1; ctrl_wdata = 10'h3FF;
      @(negedge clk); ctrl_we = 1'b0;
    end
    while (ctrl_rdata[15]) @(negedge clk);
    repeat (hold) @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrl_rdata", ctrl_rdata, 16'h0000);
    chk("R1 ce_n", {14'd0, ce_n}, 16'h0003);
    chk("R1 sclk", {15'd0, sclk}, 16'h0001);
    chk("R1 sdo_oe", {14'd0, sdo, sdo_oe}, 16'h0000);
    chk("R1 tx_ready rx_valid", {14'd0, tx_ready, rx_valid}, 16'h0002);
    cmp_on = 1;

    wr_ctrl(10'h008); send(8'hA5, 1, 0);          // div0 ce0 lsb write edge0 pol0
    wr_ctrl(10'h351); send(8'h3C, 0, 0);          // div1 ce1 msb write edge1 pol1
    wr_ctrl(10'h0DA); send(8'h00, 1, 5);          // div2 both msb read edge0
    wr_ctrl(10'h328); send(8'h96, 0, 0);          // continuous, edge1 pol1
    send(8'h5A, 0, 0);                            // R4 held between frames
    wr_ctrl(10'h329);                             // same select, still held
    wr_ctrl(10'h330);                             // select change releases
    wr_ctrl(10'h187); send(8'h00, 0, 3);          // div7 no line, read edge1
    wr_ctrl(10'h2BB); send(8'h00, 0, 1);          // continuous read edge0 pol1
    wr_ctrl(10'h29B);                             // continuous bit cleared releases
    wr_ctrl(10'h042); send(8'hC3, 0, 0);          // div2 no line msb write
    repeat (4) @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule